// File: doc/BRIEF.md
# Power-Up Reset Sequencer

This block runs on a free-running low-power clock and releases the on-chip resets in a fixed order after power is applied. It takes two supply-good indications, one for the I/O rail and one for the core rail. Each indication first passes through a synchronizer.

The sequence has four steps:

1. Once the I/O rail is good, the I/O power-on reset is held for a fixed debounce time and then released.
2. Only after that is the core rail considered. Its power-on reset is released after its own debounce time.
3. At the core release the crystal oscillator is enabled, and a warm-up time is counted.
4. Finally the baseband reset is released. In the same cycle a one-cycle pulse tells the boot logic to start fetching configuration from external memory.

All delays are parameters in clock cycles. At a 128 kHz clock, 2 ms is 256 cycles and 5 ms is 640 cycles. Losing either supply sends the block straight back to its initial state and reasserts all resets. The current state is exported so the ordering can be observed.

Top module: `por_boot_seq`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it rises, state_o is 0 and every output is low. Low on a reset output means the reset is asserted.
- R2: After io_pwr_ok_i rises, state_o goes from 0 to 1 after SYNC_STAGES+1 clock edges. It stays 1 for exactly IO_DLY_CYC cycles, then goes to 2, and io_por_n_o goes high at the same moment.
- R3: The core rail is evaluated only in state 2. From the cycle after the synchronized core-good is seen there, state_o is 3 for exactly CORE_DLY_CYC cycles. After that, core_por_n_o and xtal_en_o go high together as state_o becomes 4.
- R4: state_o stays 4 for exactly XTAL_DLY_CYC cycles. It then becomes 5, and bb_rst_n_o goes high.
- R5: boot_start_o is high for exactly one cycle, the first cycle of state 5. It never pulses again until a new complete sequence reaches state 5.
- R6: All outputs drop to low SYNC_STAGES edges after a supply-good falls, and state_o is 0 one edge later. This applies to io_pwr_ok_i falling in any state other than 0, and to core_pwr_ok_i falling in states 3, 4 or 5.
- R7: If the I/O rail drops during its debounce, the debounce restarts from zero. A full IO_DLY_CYC cycles of state 1 are then needed again.
- R8: A core supply-good that arrives before the I/O supply-good does not advance the sequence. state_o stays 0 until the I/O rail is good.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running low-power clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| io_pwr_ok_i | input | 1 | I/O rail supply-good (asynchronous) |
| core_pwr_ok_i | input | 1 | Core rail supply-good (asynchronous) |
| io_por_n_o | output | 1 | I/O power-on reset, active low |
| core_por_n_o | output | 1 | Core power-on reset, active low |
| xtal_en_o | output | 1 | Crystal oscillator enable |
| bb_rst_n_o | output | 1 | Baseband reset, active low |
| boot_start_o | output | 1 | One-cycle pulse that starts the boot fetch |
| state_o | output | 3 | Current state: 0 wait I/O, 1 I/O debounce, 2 wait core, 3 core debounce, 4 warm-up, 5 running |

## Verification
The bench builds the block with SYNC_STAGES=2 and with delays of 6, 5 and 9 cycles instead of the 256, 256 and 640 defaults. This makes a full power-up take tens of cycles, so one run covers several complete sequences. It also reaches the edges of each timed window: the last cycle of each wait and the first cycle after it. Short windows also make room for a supply loss in the running state and a glitch inside the I/O debounce. After both, the bench confirms that the restart takes the full debounce and that the boot pulse appears only once per completed sequence.

// File: rtl/por_seq_pkg.sv
package por_seq_pkg;

  typedef enum logic [2:0] {
    ST_WAIT_IO   = 3'd0,
    ST_IO_DLY    = 3'd1,
    ST_WAIT_CORE = 3'd2,
    ST_CORE_DLY  = 3'd3,
    ST_XTAL_WARM = 3'd4,
    ST_RUN       = 3'd5
  } por_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/por_sync.sv
module por_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] ff_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ff_q <= '0;
        else         ff_q <= {ff_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = ff_q[STAGES-1];

endmodule

// File: rtl/por_delay_timer.sv
module por_delay_timer #(
  parameter int unsigned CW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          run_i,
  input  logic [CW-1:0] limit_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (run_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign done_o = run_i && (cnt_q == limit_i - 1'b1);

  // the count never passes the window length of the current wait
  p_cnt_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (cnt_q < limit_i));

endmodule

// File: rtl/por_seq_fsm.sv
module por_seq_fsm
  import por_seq_pkg::*;
#(
  parameter int unsigned CW           = 10,
  parameter int unsigned IO_DLY_CYC   = 256,
  parameter int unsigned CORE_DLY_CYC = 256,
  parameter int unsigned XTAL_DLY_CYC = 640
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          io_ok_i,
  input  logic          core_ok_i,
  input  logic          done_i,
  output logic          run_o,
  output logic          clear_o,
  output logic [CW-1:0] limit_o,
  output logic          drop_o,
  output por_state_e    state_o,
  output logic          boot_o
);

  por_state_e state_q, state_d;
  logic       boot_q;

  assign drop_o = (!io_ok_i && state_q != ST_WAIT_IO) ||
                  (!core_ok_i && state_q >= ST_CORE_DLY);

  always_comb begin
    state_d = state_q;
    if (drop_o) begin
      state_d = ST_WAIT_IO;
    end else begin
      unique case (state_q)
        ST_WAIT_IO:   if (io_ok_i)   state_d = ST_IO_DLY;
        ST_IO_DLY:    if (done_i)    state_d = ST_WAIT_CORE;
        ST_WAIT_CORE: if (core_ok_i) state_d = ST_CORE_DLY;
        ST_CORE_DLY:  if (done_i)    state_d = ST_XTAL_WARM;
        ST_XTAL_WARM: if (done_i)    state_d = ST_RUN;
        ST_RUN:       state_d = ST_RUN;
        default:      state_d = ST_WAIT_IO;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_IO_DLY:    limit_o = CW'(IO_DLY_CYC);
      ST_CORE_DLY:  limit_o = CW'(CORE_DLY_CYC);
      ST_XTAL_WARM: limit_o = CW'(XTAL_DLY_CYC);
      default:      limit_o = CW'(1);
    endcase
  end

  assign run_o   = !drop_o && (state_q == ST_IO_DLY || state_q == ST_CORE_DLY ||
                               state_q == ST_XTAL_WARM);
  assign clear_o = (state_d != state_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_WAIT_IO;
      boot_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      boot_q  <= (state_q == ST_XTAL_WARM) && (state_d == ST_RUN);
    end
  end

  assign state_o = state_q;
  assign boot_o  = boot_q;

  p_io_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_ok_i |=> (state_q == ST_WAIT_IO));

  p_core_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!core_ok_i && state_q >= ST_CORE_DLY) |=> (state_q == ST_WAIT_IO));

  p_core_gated_by_io_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_IO) |=> (state_q == ST_WAIT_IO || state_q == ST_IO_DLY));

endmodule

// File: rtl/por_boot_seq.sv
module por_boot_seq
  import por_seq_pkg::*;
#(
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned IO_DLY_CYC   = 256,
  parameter int unsigned CORE_DLY_CYC = 256,
  parameter int unsigned XTAL_DLY_CYC = 640
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       io_pwr_ok_i,
  input  logic       core_pwr_ok_i,
  output logic       io_por_n_o,
  output logic       core_por_n_o,
  output logic       xtal_en_o,
  output logic       bb_rst_n_o,
  output logic       boot_start_o,
  output logic [2:0] state_o
);

  localparam int unsigned MAX_DLY = max3(IO_DLY_CYC, CORE_DLY_CYC, XTAL_DLY_CYC);
  localparam int unsigned CW      = $clog2(MAX_DLY + 1);

  logic          io_ok_s, core_ok_s;
  logic          t_run, t_clear, t_done, drop, boot;
  logic [CW-1:0] t_limit;
  por_state_e    st;

  por_sync #(.STAGES(SYNC_STAGES)) i_sync_io (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(io_pwr_ok_i), .q_o(io_ok_s)
  );

  por_sync #(.STAGES(SYNC_STAGES)) i_sync_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(core_pwr_ok_i), .q_o(core_ok_s)
  );

  por_delay_timer #(.CW(CW)) i_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .clear_i(t_clear), .run_i(t_run),
    .limit_i(t_limit), .done_o(t_done)
  );

  por_seq_fsm #(
    .CW(CW), .IO_DLY_CYC(IO_DLY_CYC), .CORE_DLY_CYC(CORE_DLY_CYC),
    .XTAL_DLY_CYC(XTAL_DLY_CYC)
  ) i_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .io_ok_i(io_ok_s), .core_ok_i(core_ok_s),
    .done_i(t_done), .run_o(t_run), .clear_o(t_clear), .limit_o(t_limit),
    .drop_o(drop), .state_o(st), .boot_o(boot)
  );

  // a supply loss pulls every output low before the state register follows
  assign io_por_n_o   = !drop && (st >= ST_WAIT_CORE);
  assign core_por_n_o = !drop && (st >= ST_XTAL_WARM);
  assign xtal_en_o    = !drop && (st >= ST_XTAL_WARM);
  assign bb_rst_n_o   = !drop && (st == ST_RUN);
  assign boot_start_o = !drop && boot;
  assign state_o      = st;

  p_core_after_io_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_por_n_o |-> io_por_n_o);

  p_xtal_after_por_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xtal_en_o |-> (core_por_n_o && io_por_n_o));

  p_bb_after_xtal_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bb_rst_n_o |-> xtal_en_o);

  p_boot_single_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_start_o |=> !boot_start_o);

  p_boot_at_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    boot_start_o |-> (bb_rst_n_o && $rose(bb_rst_n_o)));

endmodule

// File: tb/test_por_boot_seq.sv
module test_por_boot_seq;

  localparam int unsigned S = 2;
  localparam int unsigned D = 6;
  localparam int unsigned C = 5;
  localparam int unsigned X = 9;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       io_ok = 1'b0;
  logic       core_ok = 1'b0;
  logic       io_por_n, core_por_n, xtal_en, bb_rst_n, boot;
  logic [2:0] state;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int         cyc;
    logic [7:0] vec;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  por_boot_seq #(
    .SYNC_STAGES(S), .IO_DLY_CYC(D), .CORE_DLY_CYC(C), .XTAL_DLY_CYC(X)
  ) i_por_boot_seq (
    .clk_i(clk), .rst_ni(rst_ni), .io_pwr_ok_i(io_ok), .core_pwr_ok_i(core_ok),
    .io_por_n_o(io_por_n), .core_por_n_o(core_por_n), .xtal_en_o(xtal_en),
    .bb_rst_n_o(bb_rst_n), .boot_start_o(boot), .state_o(state)
  );

  // {boot, bb_rst_n, xtal_en, core_por_n, io_por_n, state}
  function automatic logic [7:0] ev(input int st, input bit b);
    logic [7:0] v;
    v[2:0] = 3'(st);
    v[3]   = (st >= 2);
    v[4]   = (st >= 4);
    v[5]   = (st >= 4);
    v[6]   = (st == 5);
    v[7]   = b;
    return v;
  endfunction

  task automatic expect_at(input int b, input int off, input logic [7:0] v, input string tag);
    exp_t e;
    e.cyc = b + off;
    e.vec = v;
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: compare the queue head when its cycle comes up
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc == cyc) begin
      exp_t e;
      logic [7:0] act;
      e   = q.pop_front();
      act = {boot, bb_rst_n, xtal_en, core_por_n, io_por_n, state};
      checks++;
      if (act !== e.vec) begin
        errors++;
        $display("FAIL %s cycle %0d actual %b expected %b", e.tag, cyc, act, e.vec);
      end
    end
  end

  initial begin
    int b;
    wait_n(3);
    // R1: reset held
    checks++;
    if ({boot, bb_rst_n, xtal_en, core_por_n, io_por_n, state} !== 8'h00) begin
      errors++;
      $display("FAIL R1 in reset actual %b expected %b",
               {boot, bb_rst_n, xtal_en, core_por_n, io_por_n, state}, 8'h00);
    end
    rst_ni = 1'b1;

    // R8: core good first does not advance
    b = cyc; core_ok = 1'b1;
    expect_at(b, 1, ev(0, 0), "R1");
    expect_at(b, 8, ev(0, 0), "R8");
    wait_n(8);

    // full power-up: R2 R3 R4 R5
    b = cyc; io_ok = 1'b1;
    expect_at(b, S,             ev(0, 0), "R2");
    expect_at(b, S+1,           ev(1, 0), "R2");
    expect_at(b, S+D,           ev(1, 0), "R2");
    expect_at(b, S+1+D,         ev(2, 0), "R2");
    expect_at(b, S+2+D,         ev(3, 0), "R3");
    expect_at(b, S+1+D+C,       ev(3, 0), "R3");
    expect_at(b, S+2+D+C,       ev(4, 0), "R3");
    expect_at(b, S+1+D+C+X,     ev(4, 0), "R4");
    expect_at(b, S+2+D+C+X,     ev(5, 1), "R5");
    expect_at(b, S+3+D+C+X,     ev(5, 0), "R5");
    expect_at(b, S+18+D+C+X,    ev(5, 0), "R5");
    wait_n(S+18+D+C+X);

    // R6: core loss in running state
    b = cyc; core_ok = 1'b0;
    expect_at(b, 1,     ev(5, 0), "R6");
    expect_at(b, S,     8'd5,     "R6");
    expect_at(b, S+1,   ev(0, 0), "R6");
    expect_at(b, S+1+D, ev(1, 0), "R6");
    expect_at(b, S+2+D, ev(2, 0), "R6");
    expect_at(b, S+4+D, ev(2, 0), "R3");
    wait_n(S+4+D);

    // core returns while waiting in state 2
    b = cyc; core_ok = 1'b1;
    expect_at(b, S,       ev(2, 0), "R3");
    expect_at(b, S+1,     ev(3, 0), "R3");
    expect_at(b, S+1+C,   ev(4, 0), "R3");
    expect_at(b, S+1+C+X, ev(5, 1), "R5");
    expect_at(b, S+2+C+X, ev(5, 0), "R5");
    wait_n(S+2+C+X);

    // R6: I/O loss in running state
    b = cyc; io_ok = 1'b0;
    expect_at(b, S,   8'd5,     "R6");
    expect_at(b, S+1, ev(0, 0), "R6");
    expect_at(b, S+3, ev(0, 0), "R6");
    wait_n(S+3);

    // R7: glitch inside the I/O debounce
    b = cyc; io_ok = 1'b1;
    expect_at(b, S+1, ev(1, 0), "R7");
    expect_at(b, S+3, ev(1, 0), "R7");
    wait_n(S+3);
    b = cyc; io_ok = 1'b0;
    expect_at(b, S,   ev(1, 0), "R7");
    expect_at(b, S+1, ev(0, 0), "R7");
    wait_n(S+1);
    b = cyc; io_ok = 1'b1;
    expect_at(b, S+1,         ev(1, 0), "R7");
    expect_at(b, S+D,         ev(1, 0), "R7");
    expect_at(b, S+1+D,       ev(2, 0), "R7");
    expect_at(b, S+2+D,       ev(3, 0), "R3");
    expect_at(b, S+2+D+C,     ev(4, 0), "R4");
    expect_at(b, S+2+D+C+X,   ev(5, 1), "R5");
    expect_at(b, S+3+D+C+X,   ev(5, 0), "R5");
    expect_at(b, S+30+D+C+X,  ev(5, 0), "R5");
    wait_n(S+30+D+C+X);

    // R1: asynchronous reset in the running state
    rst_ni = 1'b0;
    #1;
    checks++;
    if ({boot, bb_rst_n, xtal_en, core_por_n, io_por_n, state} !== 8'h00) begin
      errors++;
      $display("FAIL R1 async reset actual %b expected %b",
               {boot, bb_rst_n, xtal_en, core_por_n, io_por_n, state}, 8'h00);
    end
    wait_n(2);
    rst_ni = 1'b1;
    b = cyc;
    expect_at(b, 1,   ev(0, 0), "R1");
    expect_at(b, S+1, ev(1, 0), "R2");
    wait_n(S+2);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule